// File: doc/BRIEF.md
# GPIO Bank with Masked Writes

This block is one bank of general-purpose I/O with up to 32 pins. It sits behind a small register bus that has an address, a write strobe, a 32-bit write word and a registered 32-bit read word. Software controls three registers: output data, direction and output enable. It can also read a register that holds the sampled level of every pin. A pin is driven onto its pad only when both its direction bit and its output-enable bit are set.

Changing a few output bits normally needs a read-modify-write. Two masked-write registers avoid this. Each one covers half of the bank. Its lower half-word carries new data and its upper half-word is a per-bit keep mask, so a single write changes exactly the chosen bits. The number of implemented pins and the bank index are parameters. The bank index shifts every register offset in a fixed stride pattern.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output data, direction and output-enable registers read 0, and `pin_out` and `pin_oe` are all 0, so every pin is an input.
- R2: A write to the data register (offset 0x040 + 4·BANK_IDX) replaces every implemented output bit with the write word. A read of that offset returns the output data register.
- R3: A write to the low masked register (offset 0x000 + 8·BANK_IDX) sets output bit i (0 ≤ i ≤ 15) to write bit i only where write bit 16+i is 0. Where that bit is 1, output bit i keeps its value.
- R4: A write to the high masked register (offset 0x004 + 8·BANK_IDX) sets output bit 16+j to write bit j only where write bit 16+j is 0. Other output bits keep their values.
- R5: The direction register (offset 0x204 + 0x40·BANK_IDX) and the output-enable register (offset 0x208 + 0x40·BANK_IDX) are read/write. `pin_oe` bit i is the AND of direction bit i and output-enable bit i. `pin_out` bit i is output data bit i.
- R6: Reading the input register (offset 0x060 + 4·BANK_IDX) returns the level of each pin, whatever its direction. A change on `pin_in` shows on `rdata` at the third rising edge after it, and not at the second.
- R7: Register bits at or above NUM_PINS read as 0, and writes to those bits have no effect.
- R8: `rdata` reflects the address presented in the previous cycle. Reads of both masked-write offsets and of any unmapped address return 0.
- R9: A write to the input register changes no register and no pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word, registered, for the previous cycle's address |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output values to the pads |
| pin_oe | output | NUM_PINS | Per-pin pad drive enable |

## Verification
A write takes effect at the clock edge that samples it. The bench therefore checks `pin_out` and `pin_oe` at the falling edge right after that write cycle, and reads the value back one cycle after the address is presented. Pin inputs need three edges to reach `rdata`: two synchroniser flops and the read register. The bench checks that the old value is still visible after two edges and that the new value is visible after three. Inputs are driven and outputs sampled only on falling edges, so each result is tied to exactly one rising edge.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic lo;
    logic hi;
    logic dat;
    logic din;
    logic dir;
    logic oen;
  } gpb_sel_t;

  function automatic int off_lo(input int b);  return 8 * b;             endfunction
  function automatic int off_hi(input int b);  return 4 + 8 * b;         endfunction
  function automatic int off_dat(input int b); return 'h40 + 4 * b;      endfunction
  function automatic int off_din(input int b); return 'h60 + 4 * b;      endfunction
  function automatic int off_dir(input int b); return 'h204 + 'h40 * b;  endfunction
  function automatic int off_oen(input int b); return 'h208 + 'h40 * b;  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  gpb_sel_t            sel,
  input  logic [BUS_W-1:0]    wdata,
  output logic [NUM_PINS-1:0] dout_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] oen_q,
  output logic [NUM_PINS-1:0] oe_q
);
  logic [NUM_PINS-1:0] dout_d, dir_d, oen_d;
  logic wr_lo, wr_hi, wr_dat;

  assign wr_lo  = we && sel.lo;
  assign wr_hi  = we && sel.hi;
  assign wr_dat = we && sel.dat;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    if (i < HALF_W) begin : g_low
      always_comb begin
        if (wr_dat)                         dout_d[i] = wdata[i];
        else if (wr_lo && !wdata[HALF_W+i]) dout_d[i] = wdata[i];
        else                                dout_d[i] = dout_q[i];
      end
    end else begin : g_high
      always_comb begin
        if (wr_dat)                    dout_d[i] = wdata[i];
        else if (wr_hi && !wdata[i])   dout_d[i] = wdata[i-HALF_W];
        else                           dout_d[i] = dout_q[i];
      end
    end
  end

  assign dir_d = (we && sel.dir) ? wdata[NUM_PINS-1:0] : dir_q;
  assign oen_d = (we && sel.oen) ? wdata[NUM_PINS-1:0] : oen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      oen_q  <= '0;
      oe_q   <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      oen_q  <= oen_d;
      oe_q   <= dir_d & oen_d;
    end
  end
endmodule

// File: rtl/gpb_rdback.sv
module gpb_rdback
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  gpb_sel_t            sel,
  input  logic [NUM_PINS-1:0] dout_q,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] oen_q,
  input  logic [NUM_PINS-1:0] din_q,
  output logic [BUS_W-1:0]    rdata
);
  logic [NUM_PINS-1:0] pick;

  always_comb begin
    pick = '0;
    if (sel.dat) pick = dout_q;
    if (sel.din) pick = din_q;
    if (sel.dir) pick = dir_q;
    if (sel.oen) pick = oen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= BUS_W'(pick);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BANK_IDX = 0,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(off_lo(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(off_hi(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(off_dat(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_DIN = ADDR_W'(off_din(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(off_dir(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(off_oen(BANK_IDX));

  gpb_sel_t sel;
  logic [NUM_PINS-1:0] dout_q, dir_q, oen_q, din_q;

  always_comb begin
    sel.lo  = (addr == A_LO);
    sel.hi  = (addr == A_HI);
    sel.dat = (addr == A_DAT);
    sel.din = (addr == A_DIN);
    sel.dir = (addr == A_DIR);
    sel.oen = (addr == A_OEN);
  end

  gpb_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(din_q)
  );

  gpb_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .we(we), .sel(sel), .wdata(wdata),
    .dout_q(dout_q), .dir_q(dir_q), .oen_q(oen_q), .oe_q(pin_oe)
  );

  gpb_rdback #(.NUM_PINS(NUM_PINS)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .dout_q(dout_q), .dir_q(dir_q),
    .oen_q(oen_q), .din_q(din_q), .rdata(rdata)
  );

  assign pin_out = dout_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BANK_IDX = 0,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                we,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         wdata,
  input logic [31:0]         rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  localparam logic [31:0] IMPL = (NUM_PINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_PINS) - 32'd1);

  logic hit_lo, hit_hi, hit_dat, hit_dir, hit_oen;
  logic [NUM_PINS-1:0] keep_lo, upd_lo, dat_lo, keep_hi, upd_hi, dat_hi;

  assign hit_lo  = (addr == ADDR_W'(off_lo(BANK_IDX)));
  assign hit_hi  = (addr == ADDR_W'(off_hi(BANK_IDX)));
  assign hit_dat = (addr == ADDR_W'(off_dat(BANK_IDX)));
  assign hit_dir = (addr == ADDR_W'(off_dir(BANK_IDX)));
  assign hit_oen = (addr == ADDR_W'(off_oen(BANK_IDX)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_m
    if (i < HALF_W) begin : g_l
      assign keep_lo[i] = wdata[HALF_W+i];
      assign upd_lo[i]  = ~wdata[HALF_W+i];
      assign dat_lo[i]  = wdata[i];
      assign keep_hi[i] = 1'b1;
      assign upd_hi[i]  = 1'b0;
      assign dat_hi[i]  = 1'b0;
    end else begin : g_h
      assign keep_lo[i] = 1'b1;
      assign upd_lo[i]  = 1'b0;
      assign dat_lo[i]  = 1'b0;
      assign keep_hi[i] = wdata[i];
      assign upd_hi[i]  = ~wdata[i];
      assign dat_hi[i]  = wdata[i-HALF_W];
    end
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(we) && ($past(hit_lo) || $past(hit_hi) || $past(hit_dat))))
      |-> $stable(pin_out));

  p_low_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we && hit_lo))
      |-> (((pin_out ^ $past(pin_out)) & $past(keep_lo)) == '0 &&
           ((pin_out ^ $past(dat_lo)) & $past(upd_lo)) == '0));

  p_high_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we && hit_hi))
      |-> (((pin_out ^ $past(pin_out)) & $past(keep_hi)) == '0 &&
           ((pin_out ^ $past(dat_hi)) & $past(upd_hi)) == '0));

  p_oe_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(we) && ($past(hit_dir) || $past(hit_oen))))
      |-> $stable(pin_oe));

  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~IMPL) == 32'd0);

  p_wo_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(hit_lo) || $past(hit_hi))) |-> rdata == 32'd0);
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PINS(NUM_PINS), .BANK_IDX(BANK_IDX), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 22;
  localparam int B  = 1;
  localparam int AW = 12;
  localparam logic [31:0] IMPL = (32'd1 << N) - 32'd1;

  localparam logic [AW-1:0] A_LO  = AW'(8 * B);
  localparam logic [AW-1:0] A_HI  = AW'(4 + 8 * B);
  localparam logic [AW-1:0] A_DAT = AW'('h40 + 4 * B);
  localparam logic [AW-1:0] A_DIN = AW'('h60 + 4 * B);
  localparam logic [AW-1:0] A_DIR = AW'('h204 + 'h40 * B);
  localparam logic [AW-1:0] A_OEN = AW'('h208 + 'h40 * B);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [N-1:0] exp_out;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NUM_PINS(N), .BANK_IDX(B), .ADDR_W(AW)) u_gpio_bank (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  function automatic logic [N-1:0] apply_lo(input logic [N-1:0] cur, input logic [31:0] d);
    logic [N-1:0] r = cur;
    for (int i = 0; i < 16; i++) if (!d[16+i]) r[i] = d[i];
    return r;
  endfunction

  function automatic logic [N-1:0] apply_hi(input logic [N-1:0] cur, input logic [31:0] d);
    logic [N-1:0] r = cur;
    for (int j = 0; j < 16; j++) if (16 + j < N && !d[16+j]) r[16+j] = d[j];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pin_out", 32'(pin_out), 32'd0);
    chk("R1 pin_oe", 32'(pin_oe), 32'd0);
    rd(A_DAT, rv); chk("R1 data", rv, 32'd0);
    rd(A_DIR, rv); chk("R1 dir", rv, 32'd0);
    rd(A_OEN, rv); chk("R1 oen", rv, 32'd0);

    // R2 and R7 full data write, upper bits dropped
    wr(A_DAT, 32'hFFFF_FFFF);
    exp_out = '1;
    chk("R2 pin_out all ones", 32'(pin_out), 32'(exp_out));
    rd(A_DAT, rv); chk("R7 data readback masked", rv, IMPL);
    wr(A_DAT, 32'h1234_5678);
    exp_out = N'(32'h1234_5678);
    chk("R2 pin_out pattern", 32'(pin_out), 32'(exp_out));
    rd(A_DAT, rv); chk("R2 data readback", rv, 32'h1234_5678 & IMPL);

    // R3 sweep each low bit alone, both polarities
    for (int k = 0; k < 16; k++) begin
      logic [31:0] d;
      d = {~(16'h1 << k), (k % 2 == 0) ? ~exp_out[15:0] : 16'hA5C3 ^ 16'(k)};
      exp_out = apply_lo(exp_out, d);
      wr(A_LO, d);
      chk($sformatf("R3 low bit %0d", k), 32'(pin_out), 32'(exp_out));
    end
    wr(A_LO, 32'hFFFF_0000 | 32'(~exp_out[15:0]));
    chk("R3 full keep mask", 32'(pin_out), 32'(exp_out));
    wr(A_LO, 32'h0000_BEEF);
    exp_out = apply_lo(exp_out, 32'h0000_BEEF);
    chk("R3 no mask", 32'(pin_out), 32'(exp_out));

    // R4 sweep high bits, including unimplemented ones (R7)
    for (int k = 0; k < 16; k++) begin
      logic [31:0] d;
      d = {~(16'h1 << k), 16'(1 << k) ^ {16{exp_out[16 + (k % (N-16))]}}};
      exp_out = apply_hi(exp_out, d);
      wr(A_HI, d);
      chk($sformatf("R4 high bit %0d", 16 + k), 32'(pin_out), 32'(exp_out));
    end
    rd(A_DAT, rv); chk("R7 data after high sweep", rv, 32'(exp_out));

    // R8 write-only and unmapped reads
    rd(A_LO, rv); chk("R8 low masked read", rv, 32'd0);
    rd(A_HI, rv); chk("R8 high masked read", rv, 32'd0);
    rd(AW'('h3FC), rv); chk("R8 unmapped read", rv, 32'd0);

    // R5 direction and enable combos
    wr(A_DIR, 32'h00F0_F0F0);
    chk("R5 oe with dir only", 32'(pin_oe), 32'd0);
    wr(A_OEN, 32'hFFCC_CCCC);
    chk("R5 oe and", 32'(pin_oe), 32'h00F0_F0F0 & 32'hFFCC_CCCC & IMPL);
    rd(A_DIR, rv); chk("R5 dir readback", rv, 32'h00F0_F0F0 & IMPL);
    rd(A_OEN, rv); chk("R7 oen readback", rv, 32'hFFCC_CCCC & IMPL);
    chk("R5 pin_out follows data", 32'(pin_out), 32'(exp_out));

    // R9 write to input register ignored
    wr(A_DIN, 32'hFFFF_FFFF);
    chk("R9 pin_out unchanged", 32'(pin_out), 32'(exp_out));
    chk("R9 pin_oe unchanged", 32'(pin_oe), 32'h00F0_F0F0 & 32'hFFCC_CCCC & IMPL);
    rd(A_DAT, rv); chk("R9 data unchanged", rv, 32'(exp_out));

    // R6 input latency, independent of direction
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] v;
      logic [N-1:0] old;
      v = N'(32'h2A_5A5A * (p + 3) ^ (p * 32'h1_1111));
      addr = A_DIN;
      @(negedge clk); @(negedge clk); @(negedge clk);
      old = rdata[N-1:0];
      pin_in = v;
      @(negedge clk); @(negedge clk);
      if (v != old) chk($sformatf("R6 not yet after 2 edges p%0d", p), rdata, 32'(old));
      @(negedge clk);
      chk($sformatf("R6 input after 3 edges p%0d", p), rdata, 32'(v));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule